// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster control signals for a flat panel: a pixel-clock enable pulse, horizontal sync, vertical sync and a data-enable window. Software-visible settings arrive as three 32-bit words (horizontal geometry, vertical geometry, and clock/polarity configuration) plus one enable bit. The pixel clock is derived from the system clock by an integer divisor. A panel-type input raises the smallest allowed divisor, so that active-matrix and passive panels both receive a legal pixel rate.

Each frame latches its own copy of the settings at its first pixel, so register writes never tear a frame in progress. Clearing the enable bit asks for a graceful stop: the running frame is completed and a sticky done flag is then raised. An underflow input stands in for the pixel FIFO that feeds the panel. When the FIFO runs dry during the visible window, an underflow error is reported. When it is already dry at the first visible pixel of a frame, a sync-lost error is reported as well. Both errors are cleared by disabling the block.

Top module: `lcdt_timing`

## Requirements
- R1: Horizontal word: bits 9:0 visible pixels minus 1, bits 15:10 sync width minus 1, bits 23:16 front porch minus 1, bits 31:24 back porch minus 1. Each line runs sync, back porch, visible, front porch, one pixel per pixel-clock enable.
- R2: Vertical word: bits 9:0 visible lines minus 1, bits 15:10 sync width minus 1, bits 23:16 front porch and bits 31:24 back porch as literal line counts. The lines follow the same order, and the line counter advances once per completed line.
- R3: The configuration word bits 7:0 give the divisor. The value in use is raised to 2 when panel_active is 1 and to 3 when it is 0, with 255 as its top. pix_ce is a single-clock pulse every divisor clocks.
- R4: Configuration bit 20 inverts hsync and bit 21 inverts vsync (0 = sync driven high). Bits 15:8 and bits 25:22 change no output.
- R5: When en goes low, the running frame still completes in full. After that, pix_ce and de stay low.
- R6: frame_done rises at the last pixel of the frame that ends while en is low. It holds until en is 1 again, and the next clock clears it.
- R7: underflow_err is set when fifo_underflow is high in a clock where de is high. It is cleared, and held clear, by en low.
- R8: sync_lost is set together with underflow_err when the underflow coincides with the first visible pixel of a frame. It is cleared by en low.
- R9: Register words written during a frame take effect at the start of the next frame.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable / graceful stop request |
| htim | input | 32 | Horizontal geometry word |
| vtim | input | 32 | Vertical geometry word |
| ctim | input | 32 | Divisor, bias count and polarity word |
| panel_active | input | 1 | 1 = active-matrix panel, 0 = passive panel |
| fifo_underflow | input | 1 | Pixel FIFO empty indication |
| pix_ce | output | 1 | Pixel-clock enable pulse |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Visible-pixel data enable |
| frame_done | output | 1 | Sticky graceful-stop completion flag |
| underflow_err | output | 1 | FIFO underflow during visible pixels |
| sync_lost | output | 1 | FIFO empty at frame's first visible pixel |

## Verification
Two pairs of events can land on the same clock edge. An underflow on the very first visible pixel must set both error flags on one edge. The bench raises fifo_underflow for exactly that clock and expects both flags together at the next sample. A disable request can also collide with a frame boundary or with a register rewrite in mid-frame. The bench counts the pixel enables up to frame_done and requires exactly one frame (or exactly the old frame plus one new-geometry frame).

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int CNT_W = 12;
  localparam int DIV_W = 8;
  localparam int HPOL_BIT = 20;
  localparam int VPOL_BIT = 21;

  typedef struct packed {
    logic [CNT_W-1:0] sync_end;
    logic [CNT_W-1:0] act_start;
    logic [CNT_W-1:0] act_end;
    logic [CNT_W-1:0] total;
  } axis_lim_t;

  // horizontal: every field stored minus one
  function automatic axis_lim_t decode_h(input logic [31:0] r);
    axis_lim_t d;
    logic [CNT_W-1:0] s, b, a, f;
    s = CNT_W'(r[15:10]) + CNT_W'(1);
    b = CNT_W'(r[31:24]) + CNT_W'(1);
    a = CNT_W'(r[9:0]) + CNT_W'(1);
    f = CNT_W'(r[23:16]) + CNT_W'(1);
    d.sync_end  = s;
    d.act_start = s + b;
    d.act_end   = s + b + a;
    d.total     = s + b + a + f;
    return d;
  endfunction

  // vertical: porches are literal counts
  function automatic axis_lim_t decode_v(input logic [31:0] r);
    axis_lim_t d;
    logic [CNT_W-1:0] s, b, a, f;
    s = CNT_W'(r[15:10]) + CNT_W'(1);
    b = CNT_W'(r[31:24]);
    a = CNT_W'(r[9:0]) + CNT_W'(1);
    f = CNT_W'(r[23:16]);
    d.sync_end  = s;
    d.act_start = s + b;
    d.act_end   = s + b + a;
    d.total     = s + b + a + f;
    return d;
  endfunction
endpackage

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  assign tick = run && (cnt == div - DW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DW'(1);
  end
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
  import lcdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      restart,
  input  logic      step,
  input  axis_lim_t lim,
  output logic      in_sync,
  output logic      in_act,
  output logic      at_first,
  output logic      wrap
);
  logic [CNT_W-1:0] cnt;

  assign wrap     = (cnt == lim.total - CNT_W'(1));
  assign in_sync  = (cnt < lim.sync_end);
  assign in_act   = (cnt >= lim.act_start) && (cnt < lim.act_end);
  assign at_first = (cnt == lim.act_start);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (step)      cnt <= wrap ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/lcdt_timing.sv
module lcdt_timing
  import lcdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [31:0] htim,
  input  logic [31:0] vtim,
  input  logic [31:0] ctim,
  input  logic        panel_active,
  input  logic        fifo_underflow,
  output logic        pix_ce,
  output logic        hsync,
  output logic        vsync,
  output logic        de,
  output logic        frame_done,
  output logic        underflow_err,
  output logic        sync_lost
);
  localparam logic [DIV_W-1:0] MIN_ACTIVE  = DIV_W'(2);
  localparam logic [DIV_W-1:0] MIN_PASSIVE = DIV_W'(3);

  logic             running;
  axis_lim_t        lim_h, lim_v;
  logic [DIV_W-1:0] div_q, div_min, div_eff;
  logic             pol_h, pol_v;
  logic             first_q;
  logic             tick, start, frame_last;
  logic             h_sync, h_act, h_first, h_wrap;
  logic             v_sync, v_act, v_first, v_wrap;

  assign div_min    = panel_active ? MIN_ACTIVE : MIN_PASSIVE;
  assign div_eff    = (ctim[DIV_W-1:0] < div_min) ? div_min : ctim[DIV_W-1:0];
  assign start      = !running && en;
  assign frame_last = tick && h_wrap && v_wrap;

  lcdt_clkdiv #(.DW(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(running), .div(div_q), .tick(tick)
  );

  lcdt_axis u_hax (
    .clk(clk), .rst(rst), .restart(start), .step(tick), .lim(lim_h),
    .in_sync(h_sync), .in_act(h_act), .at_first(h_first), .wrap(h_wrap)
  );

  lcdt_axis u_vax (
    .clk(clk), .rst(rst), .restart(start), .step(tick && h_wrap), .lim(lim_v),
    .in_sync(v_sync), .in_act(v_act), .at_first(v_first), .wrap(v_wrap)
  );

  // frame sequencing, latched settings and registered raster outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      lim_h   <= '0;
      lim_v   <= '0;
      div_q   <= MIN_ACTIVE;
      pol_h   <= 1'b0;
      pol_v   <= 1'b0;
      pix_ce  <= 1'b0;
      hsync   <= 1'b0;
      vsync   <= 1'b0;
      de      <= 1'b0;
      first_q <= 1'b0;
    end else if (!running) begin
      pix_ce  <= 1'b0;
      de      <= 1'b0;
      first_q <= 1'b0;
      hsync   <= ctim[HPOL_BIT];
      vsync   <= ctim[VPOL_BIT];
      if (en) begin
        running <= 1'b1;
        lim_h   <= decode_h(htim);
        lim_v   <= decode_v(vtim);
        div_q   <= div_eff;
        pol_h   <= ctim[HPOL_BIT];
        pol_v   <= ctim[VPOL_BIT];
      end
    end else if (tick) begin
      pix_ce  <= 1'b1;
      hsync   <= pol_h ^ h_sync;
      vsync   <= pol_v ^ v_sync;
      de      <= h_act && v_act;
      first_q <= h_first && v_first;
      if (frame_last) begin
        if (en) begin
          lim_h <= decode_h(htim);
          lim_v <= decode_v(vtim);
          div_q <= div_eff;
          pol_h <= ctim[HPOL_BIT];
          pol_v <= ctim[VPOL_BIT];
        end else begin
          running <= 1'b0;
        end
      end
    end else begin
      pix_ce <= 1'b0;
    end
  end

  // status flags
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_done    <= 1'b0;
      underflow_err <= 1'b0;
      sync_lost     <= 1'b0;
    end else begin
      if (en)                          frame_done <= 1'b0;
      else if (running && frame_last)  frame_done <= 1'b1;

      if (!en) begin
        underflow_err <= 1'b0;
        sync_lost     <= 1'b0;
      end else if (fifo_underflow && de) begin
        underflow_err <= 1'b1;
        if (first_q) sync_lost <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcdt_timing_chk.sv
module lcdt_timing_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic pix_ce,
  input logic hsync,
  input logic vsync,
  input logic de,
  input logic frame_done,
  input logic underflow_err,
  input logic sync_lost,
  input logic pol_h,
  input logic pol_v
);
  AST_CE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pix_ce |=> !pix_ce); // R3

  AST_DE_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
    de |-> (hsync == pol_h) && (vsync == pol_v)); // R1

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !en) |=> frame_done); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (frame_done && $past(frame_done)) |-> (!pix_ce && !de)); // R5

  AST_FLAGS_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!underflow_err && !sync_lost)); // R7

  AST_SL_WITH_UF: assert property (@(posedge clk) disable iff (rst)
    sync_lost |-> underflow_err); // R8
endmodule

bind lcdt_timing lcdt_timing_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .pix_ce(pix_ce), .hsync(hsync),
  .vsync(vsync), .de(de), .frame_done(frame_done),
  .underflow_err(underflow_err), .sync_lost(sync_lost),
  .pol_h(pol_h), .pol_v(pol_v)
);

// File: tb/tb_lcdt_timing.sv
module tb_lcdt_timing;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [31:0] htim = '0, vtim = '0, ctim = '0;
  logic panel_active = 1'b1;
  logic fifo_underflow = 1'b0;
  logic pix_ce, hsync, vsync, de, frame_done, underflow_err, sync_lost;

  always #4 clk = ~clk; // 125 MHz

  lcdt_timing dut (
    .clk(clk), .rst(rst), .en(en), .htim(htim), .vtim(vtim), .ctim(ctim),
    .panel_active(panel_active), .fifo_underflow(fifo_underflow),
    .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de),
    .frame_done(frame_done), .underflow_err(underflow_err), .sync_lost(sync_lost)
  );

  typedef struct packed {
    logic [31:0] h;
    logic [31:0] v;
    logic [31:0] c;
    logic        pa;
    logic [15:0] div;
    logic [15:0] total;
    logic [15:0] hs;
    logic [15:0] vs;
    logic [15:0] den;
    logic [15:0] fde;
    logic        hlev;
    logic        vlev;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h0101_0403, 32'h0101_0002, 32'h0000_0000, 1'b1, 16'd2,   16'd60, 16'd12, 16'd10, 16'd12, 16'd24, 1'b1, 1'b1},
    '{32'h0200_0007, 32'h0000_0401, 32'h03F0_5501, 1'b0, 16'd3,   16'd52, 16'd4,  16'd26, 16'd16, 16'd30, 1'b0, 1'b0},
    '{32'h0002_0002, 32'h0002_0001, 32'h0020_0005, 1'b1, 16'd5,   16'd40, 16'd5,  16'd8,  16'd6,  16'd10, 1'b1, 1'b0},
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_00FF, 1'b0, 16'd255, 16'd8,  16'd2,  16'd4,  16'd1,  16'd6,  1'b1, 1'b1},
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 1'b1, 16'd2,   16'd8,  16'd2,  16'd4,  16'd1,  16'd6,  1'b1, 1'b1}
  };

  int tests = 0;
  int fails = 0;
  int n_tick, n_hs, n_vs, n_de, i_fde, i_fhs, gap;
  bit got_done;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // enables and counts pixels until frame_done; drops en after drop_at ticks
  task automatic run_frames(input int drop_at, input int chg_at,
                            input logic [31:0] chg_h, input bit hl, input bit vl);
    int t1;
    n_tick = 0; n_hs = 0; n_vs = 0; n_de = 0; i_fde = -1; i_fhs = -1;
    gap = 0; t1 = 0; got_done = 0;
    en = 1'b1;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (pix_ce) begin
        if (n_tick == 1) t1 = c;
        if (n_tick == 2) gap = c - t1;
        if (hsync == hl) begin n_hs++; if (i_fhs < 0) i_fhs = n_tick; end
        if (vsync == vl) n_vs++;
        if (de) begin n_de++; if (i_fde < 0) i_fde = n_tick; end
        n_tick++;
        if (n_tick == drop_at) en = 1'b0;
        if (n_tick == chg_at) htim = chg_h;
      end
      if (frame_done) begin got_done = 1; break; end
    end
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check({pix_ce, hsync, vsync, de, frame_done, underflow_err, sync_lost} == 7'b0,
          "R10 reset outputs", {pix_ce, hsync, vsync, de, frame_done, underflow_err, sync_lost}, 0);

    // vector walk: R1 R2 R3 R4 R5
    for (int k = 0; k < 5; k++) begin
      htim = VECS[k].h; vtim = VECS[k].v; ctim = VECS[k].c; panel_active = VECS[k].pa;
      @(negedge clk);
      run_frames(3, -1, '0, VECS[k].hlev, VECS[k].vlev);
      check(got_done, "R5 done after graceful stop", got_done, 1);
      check(n_tick == int'(VECS[k].total), "R5 full frame length", n_tick, VECS[k].total);
      check(gap == int'(VECS[k].div), "R3 divisor", gap, VECS[k].div);
      check(n_hs == int'(VECS[k].hs), "R1 R4 hsync pixels", n_hs, VECS[k].hs);
      check(n_vs == int'(VECS[k].vs), "R2 R4 vsync pixels", n_vs, VECS[k].vs);
      check(n_de == int'(VECS[k].den), "R1 R2 de pixels", n_de, VECS[k].den);
      check(i_fde == int'(VECS[k].fde), "R1 R2 first visible index", i_fde, VECS[k].fde);
      check(i_fhs == 0, "R1 sync first in line", i_fhs, 0);
    end

    // R6 done sticky and quiet, then cleared by en
    begin
      int ce_seen = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (pix_ce || de) ce_seen++;
      end
      check(frame_done == 1'b1, "R6 done holds", frame_done, 1);
      check(ce_seen == 0, "R5 idle after stop", ce_seen, 0);
      en = 1'b1;
      @(negedge clk);
      check(frame_done == 1'b0, "R6 done cleared by enable", frame_done, 0);
      en = 1'b0;
      while (!frame_done) @(negedge clk);
    end

    // R9 mid-frame rewrite applies from the next frame (60 + 84 pixels)
    htim = VECS[0].h; vtim = VECS[0].v; ctim = VECS[0].c; panel_active = 1'b1;
    @(negedge clk);
    run_frames(65, 5, 32'h0101_0407, 1'b1, 1'b1);
    check(n_tick == 144, "R9 old frame then new geometry", n_tick, 144);
    check(n_de == 36, "R9 visible pixels across both frames", n_de, 36);

    // R7 R8 underflow handling
    htim = VECS[0].h;
    @(negedge clk);
    en = 1'b1;
    while (!de) @(negedge clk);
    fifo_underflow = 1'b1;
    @(negedge clk);
    fifo_underflow = 1'b0;
    check(underflow_err == 1'b1, "R7 underflow at first pixel", underflow_err, 1);
    check(sync_lost == 1'b1, "R8 sync lost same edge", sync_lost, 1);
    en = 1'b0;
    @(negedge clk);
    check(underflow_err == 1'b0, "R7 cleared by disable", underflow_err, 0);
    check(sync_lost == 1'b0, "R8 cleared by disable", sync_lost, 0);
    en = 1'b1;
    @(negedge clk);
    while (!(pix_ce && de)) @(negedge clk);
    fifo_underflow = 1'b1;
    @(negedge clk);
    fifo_underflow = 1'b0;
    check(underflow_err == 1'b1, "R7 underflow later pixel", underflow_err, 1);
    check(sync_lost == 1'b0, "R8 no sync lost off first pixel", sync_lost, 0);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    while (!(pix_ce && !de)) @(negedge clk);
    fifo_underflow = 1'b1;
    @(negedge clk);
    fifo_underflow = 1'b0;
    check(underflow_err == 1'b0, "R7 ignored outside visible", underflow_err, 0);
    en = 1'b0;
    while (!frame_done) @(negedge clk);
    check(frame_done == 1'b1, "R6 done after underflow run", frame_done, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule